// File: doc/BRIEF.md
# Move-Only Bus Processor

A small processor with a single instruction: move one word from a source location to a destination location on an internal bus. Each 16-bit instruction holds a source bus address in its upper byte and a destination bus address in its lower byte. There is no opcode. All work is a side effect of touching particular bus addresses:

- Reading or writing the memory data location performs a memory access at the address held in the memory address register.
- Writing one of sixteen ALU locations combines the moved word with the accumulator.
- Reading one of sixteen condition locations returns an all-ones or an all-zeros word.

The core talks to one 16-bit word memory. It provides an 8-bit address, write data and a write strobe, and it takes back read data combinationally in the same cycle. Each instruction takes a fetch cycle and then an execute cycle. The single exception is a literal moved into memory, which needs one more cycle, because the literal and the store both need the memory port.

Top module: `ttp_core`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, the core drives address 0x00 with the write strobe low. The program counter, accumulator, memory address register, carry and skip state all clear to zero.
- R2: Instruction format and sequencing:
  - Bits 15:8 of an instruction are the source bus address and bits 7:0 are the destination bus address.
  - Each instruction is fetched in one cycle from the address in the program counter, which then advances by one.
  - The fetch cycle is followed by one execute cycle.
- R3: Source 0x00 is a literal. It reads the word that follows the instruction, using the program counter as the memory address in the execute cycle, and advances the program counter past that word.
- R4: Register locations on the bus:
  - 0x01 is the program counter. A read returns the address of the next word after the instruction, zero-extended. A write is a jump, taking effect at the next fetch.
  - 0x02 is the accumulator.
  - 0x03 is the memory address register. A write keeps the low 8 bits, and a read zero-extends them.
- R5: Location 0x04 is the memory data location:
  - A read returns the memory word at the memory address register.
  - A write asserts mem_we_o for one cycle, with mem_addr_o equal to the memory address register and mem_wdata_o equal to the moved word.
- R6: A move from source 0x00 to destination 0x04 takes three cycles. The execute cycle reads the literal at the program counter, and one further cycle writes it to the memory address register's location.
- R7: Writing destination 0x10+k applies ALU operation k to the accumulator A with the moved word V:
  - 0 add A+V, 1 subtract A-V, 2 and, 3 or, 4 xor.
  - 5 not V, 6 shift A left by V[3:0], 7 shift A right by V[3:0] (logical).
  - 8 load V, 9 V+1, 10 V-1, 11 -V.
- R8: Add sets carry to the unsigned carry out. Subtract sets carry when A < V (borrow). All other operations leave carry unchanged.
- R9: Reading source 0x20+k returns 0xFFFF when test k holds and 0x0000 otherwise. The tests are:
  - 0 A zero, 1 A nonzero, 2 A[15] set, 3 A[15] clear.
  - 4 carry set, 5 carry clear, 6 always, 7 never.
  - 8 to 15 always false.
- R10: Writing a nonzero word to destination 0x05 arms a skip. The next word fetched is then discarded: that fetch cycle advances the program counter, clears the skip and is followed by another fetch. Writing zero clears the skip.
- R11: ALU operations 12 to 15 leave the accumulator and carry unchanged. Unmapped sources read as zero, and unmapped destinations have no effect.
- R12: mem_addr_o shows the program counter during fetch and during a literal execute cycle, and the memory address register in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rdata_i | input | 16 | Memory read data for mem_addr_o, same cycle |
| mem_addr_o | output | 8 | Word address to memory |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |

## Verification
The bench builds the core with its default parameters: 8-bit bus addresses, 16-bit data and a 256-word memory. The whole address space is therefore visible to a behavioural instruction-level model. That model predicts the address, strobe and write data of every cycle for one program. The program exercises:
- literals, including a literal moved straight into memory;
- carry from subtraction and the condition reads;
- a taken skip and a not-taken skip;
- a jump over a store, a read of the program counter, and a reserved ALU code.

Final memory contents, computed by hand, confirm the arithmetic results.

// File: rtl/ttp_pkg.sv
package ttp_pkg;
  // bus locations (default 8-bit address map)
  localparam logic [7:0] LOC_LIT  = 8'h00;
  localparam logic [7:0] LOC_PC   = 8'h01;
  localparam logic [7:0] LOC_AC   = 8'h02;
  localparam logic [7:0] LOC_MAR  = 8'h03;
  localparam logic [7:0] LOC_MDR  = 8'h04;
  localparam logic [7:0] LOC_SKIP = 8'h05;
  localparam logic [3:0] PAGE_ALU  = 4'h1;
  localparam logic [3:0] PAGE_COND = 4'h2;

  typedef enum logic [1:0] {PH_FETCH = 2'd0, PH_EXEC = 2'd1, PH_HOLD = 2'd2} phase_e;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL, OP_SHR,
    OP_LD, OP_INC, OP_DEC, OP_NEG, OP_R12, OP_R13, OP_R14, OP_R15
  } alu_op_e;
endpackage

// File: rtl/ttp_alu.sv
module ttp_alu import ttp_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W:0] sum;
  assign sum = {1'b0, acc_i} + {1'b0, val_i};

  always_comb begin
    res_o   = acc_i;
    carry_o = carry_i;
    unique case (alu_op_e'(op_i))
      OP_ADD: begin res_o = sum[DATA_W-1:0]; carry_o = sum[DATA_W]; end
      OP_SUB: begin res_o = acc_i - val_i; carry_o = (acc_i < val_i); end
      OP_AND: res_o = acc_i & val_i;
      OP_OR:  res_o = acc_i | val_i;
      OP_XOR: res_o = acc_i ^ val_i;
      OP_NOT: res_o = ~val_i;
      OP_SHL: res_o = acc_i << val_i[SH_W-1:0];
      OP_SHR: res_o = acc_i >> val_i[SH_W-1:0];
      OP_LD:  res_o = val_i;
      OP_INC: res_o = val_i + 1'b1;
      OP_DEC: res_o = val_i - 1'b1;
      OP_NEG: res_o = -val_i;
      default: ;  // reserved: hold
    endcase
  end
endmodule

// File: rtl/ttp_cond.sv
module ttp_cond #(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        sel_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] word_o
);
  logic hit;
  always_comb begin
    unique case (sel_i)
      4'd0:    hit = (acc_i == '0);
      4'd1:    hit = (acc_i != '0);
      4'd2:    hit = acc_i[DATA_W-1];
      4'd3:    hit = ~acc_i[DATA_W-1];
      4'd4:    hit = carry_i;
      4'd5:    hit = ~carry_i;
      4'd6:    hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end
  assign word_o = {DATA_W{hit}};
endmodule

// File: rtl/ttp_core.sv
module ttp_core import ttp_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o
);
  localparam int PG_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] A_LIT  = ADDR_W'(LOC_LIT);
  localparam logic [ADDR_W-1:0] A_PC   = ADDR_W'(LOC_PC);
  localparam logic [ADDR_W-1:0] A_AC   = ADDR_W'(LOC_AC);
  localparam logic [ADDR_W-1:0] A_MAR  = ADDR_W'(LOC_MAR);
  localparam logic [ADDR_W-1:0] A_MDR  = ADDR_W'(LOC_MDR);
  localparam logic [ADDR_W-1:0] A_SKIP = ADDR_W'(LOC_SKIP);
  localparam logic [PG_W-1:0]   P_ALU  = PG_W'(PAGE_ALU);
  localparam logic [PG_W-1:0]   P_COND = PG_W'(PAGE_COND);

  phase_e            state_q;
  logic [2*ADDR_W-1:0] ir_q;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ac_q, hold_q;
  logic              carry_q, skip_q;

  logic [ADDR_W-1:0] src, dst, pc_inc;
  logic [DATA_W-1:0] src_val, cond_word, alu_res;
  logic              alu_carry, src_lit, dst_mdr, dst_alu, use_pc;

  assign src     = ir_q[2*ADDR_W-1:ADDR_W];
  assign dst     = ir_q[ADDR_W-1:0];
  assign pc_inc  = pc_q + 1'b1;
  assign src_lit = (src == A_LIT);
  assign dst_mdr = (dst == A_MDR);
  assign dst_alu = (dst[ADDR_W-1:4] == P_ALU);

  ttp_cond #(.DATA_W(DATA_W)) u_cond (
    .sel_i(src[3:0]), .acc_i(ac_q), .carry_i(carry_q), .word_o(cond_word)
  );

  ttp_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(dst[3:0]), .acc_i(ac_q), .val_i(src_val), .carry_i(carry_q),
    .res_o(alu_res), .carry_o(alu_carry)
  );

  always_comb begin
    src_val = '0;
    if (src == A_LIT || src == A_MDR)     src_val = mem_rdata_i;
    else if (src == A_PC)                 src_val = DATA_W'(pc_q);
    else if (src == A_AC)                 src_val = ac_q;
    else if (src == A_MAR)                src_val = DATA_W'(mar_q);
    else if (src[ADDR_W-1:4] == P_COND)   src_val = cond_word;
  end

  // address mux: PC for fetch and literal, MAR otherwise
  assign use_pc      = (state_q == PH_FETCH) || (state_q == PH_EXEC && src_lit);
  assign mem_addr_o  = use_pc ? pc_q : mar_q;
  assign mem_we_o    = (state_q == PH_HOLD) ||
                       (state_q == PH_EXEC && dst_mdr && !src_lit);
  assign mem_wdata_o = (state_q == PH_HOLD) ? hold_q : src_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_FETCH;
      ir_q    <= '0;
      pc_q    <= '0;
      mar_q   <= '0;
      ac_q    <= '0;
      hold_q  <= '0;
      carry_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      unique case (state_q)
        PH_FETCH: begin
          pc_q <= pc_inc;
          if (skip_q) skip_q <= 1'b0;
          else begin
            ir_q    <= mem_rdata_i;
            state_q <= PH_EXEC;
          end
        end
        PH_EXEC: begin
          state_q <= PH_FETCH;
          if (dst == A_PC)  pc_q <= src_val[ADDR_W-1:0];
          else if (src_lit) pc_q <= pc_inc;
          if (src_lit && dst_mdr) begin
            hold_q  <= src_val;
            state_q <= PH_HOLD;
          end
          if (dst == A_AC)   ac_q   <= src_val;
          if (dst == A_MAR)  mar_q  <= src_val[ADDR_W-1:0];
          if (dst == A_SKIP) skip_q <= |src_val;
          if (dst_alu) begin
            ac_q    <= alu_res;
            carry_q <= alu_carry;
          end
        end
        default: state_q <= PH_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/ttp_chk.sv
module ttp_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        state_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] mar_i,
  input logic              skip_i,
  input logic [DATA_W-1:0] cond_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_we_i
);
  assert_fetch_addr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd0) |-> (mem_addr_i == pc_i && !mem_we_i));

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd0) |=> (pc_i == ADDR_W'($past(pc_i) + 1'b1)));

  assert_store_mar_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (mem_addr_i == mar_i));

  assert_hold_seq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd2) |-> ($past(state_i) == 2'd1 && mem_we_i));

  assert_skip_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd0 && skip_i) |=> (state_i == 2'd0 && !skip_i));

  assert_cond_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == '0) || (cond_i == '1));
endmodule

bind ttp_core ttp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q), .pc_i(pc_q),
  .mar_i(mar_q), .skip_i(skip_q), .cond_i(cond_word),
  .mem_addr_i(mem_addr_o), .mem_we_i(mem_we_o)
);

// File: tb/sim_ttp_core.sv
`timescale 1ns/1ps
module sim_ttp_core;
  localparam int RUN = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] rdata, wdata;
  logic [7:0]  addr;
  logic        we;
  logic [15:0] mem [256];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rdata = mem[addr];
  always_ff @(posedge clk) if (we) mem[addr] <= wdata;

  ttp_core u0 (.clk_i(clk), .rst_ni(rst_n), .mem_rdata_i(rdata),
               .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we));

  // reference model state
  logic [15:0] m_mem [256];
  logic [7:0]  m_pc, m_mar;
  logic [15:0] m_ac;
  logic        m_c, m_skip;
  logic [7:0]  q_addr[$];
  logic        q_we[$];
  logic [15:0] q_wd[$];
  string       q_tag[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] a, logic w, logic [15:0] d, string t);
    q_addr.push_back(a); q_we.push_back(w); q_wd.push_back(d); q_tag.push_back(t);
  endtask

  function automatic bit cond_ref(logic [3:0] k);
    case (k)
      0: return m_ac == 0;
      1: return m_ac != 0;
      2: return m_ac[15];
      3: return !m_ac[15];
      4: return m_c;
      5: return !m_c;
      6: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic alu_ref(logic [3:0] op, logic [15:0] v);
    logic [16:0] s;
    case (op)
      0: begin s = m_ac + v; m_ac = s[15:0]; m_c = s[16]; end
      1: begin m_c = (m_ac < v); m_ac = m_ac - v; end
      2: m_ac = m_ac & v;
      3: m_ac = m_ac | v;
      4: m_ac = m_ac ^ v;
      5: m_ac = ~v;
      6: m_ac = m_ac << v[3:0];
      7: m_ac = m_ac >> v[3:0];
      8: m_ac = v;
      9: m_ac = v + 1;
      10: m_ac = v - 1;
      11: m_ac = -v;
      default: ;
    endcase
  endtask

  task automatic model_instr();
    logic [15:0] ir, v;
    logic [7:0]  s, d, la;
    bit lit;
    if (m_skip) begin
      push(m_pc, 0, 0, "R10"); m_pc++; m_skip = 0; return;
    end
    push(m_pc, 0, 0, "R2");
    ir = m_mem[m_pc]; m_pc++;
    s = ir[15:8]; d = ir[7:0];
    lit = 0; la = m_pc; v = 0;
    if (s == 8'h00) begin v = m_mem[m_pc]; m_pc++; lit = 1; end
    else if (s == 8'h01) v = {8'h00, m_pc};
    else if (s == 8'h02) v = m_ac;
    else if (s == 8'h03) v = {8'h00, m_mar};
    else if (s == 8'h04) v = m_mem[m_mar];
    else if (s[7:4] == 4'h2) v = cond_ref(s[3:0]) ? 16'hFFFF : 16'h0000;
    if (d == 8'h04) begin
      if (lit) begin push(la, 0, 0, "R3"); push(m_mar, 1, v, "R6"); end
      else push(m_mar, 1, v, "R5");
      m_mem[m_mar] = v;
    end else push(lit ? la : m_mar, 0, 0, lit ? "R3" : "R12");
    if (d == 8'h01) m_pc = v[7:0];
    else if (d == 8'h02) m_ac = v;
    else if (d == 8'h03) m_mar = v[7:0];
    else if (d == 8'h05) m_skip = (v != 0);
    else if (d[7:4] == 4'h1) alu_ref(d[3:0], v);
  endtask

  function automatic logic [15:0] mv(logic [7:0] s, logic [7:0] d);
    return {s, d};
  endfunction

  task automatic put(int a, logic [15:0] w);
    mem[a] = w; m_mem[a] = w;
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) put(i, 16'h0000);
    put(0,  mv(8'h00, 8'h03)); put(1,  16'h0080);  // MAR=80
    put(2,  mv(8'h00, 8'h02)); put(3,  16'h0005);  // AC=5
    put(4,  mv(8'h00, 8'h10)); put(5,  16'h0003);  // add 3
    put(6,  mv(8'h02, 8'h04));                     // [80]=8
    put(7,  mv(8'h00, 8'h03)); put(8,  16'h0081);
    put(9,  mv(8'h00, 8'h04)); put(10, 16'h1234);  // literal to memory
    put(11, mv(8'h04, 8'h11));                     // sub [81]
    put(12, mv(8'h24, 8'h04));                     // carry -> [81]
    put(13, mv(8'h22, 8'h05));                     // negative -> skip
    put(14, mv(8'h02, 8'h04));                     // skipped
    put(15, mv(8'h20, 8'h05));                     // zero: false
    put(16, mv(8'h00, 8'h14)); put(17, 16'hFFFF);  // xor
    put(18, mv(8'h00, 8'h03)); put(19, 16'h0082);
    put(20, mv(8'h02, 8'h04));                     // [82]
    put(21, mv(8'h00, 8'h16)); put(22, 16'h0004);  // shl 4
    put(23, mv(8'h00, 8'h01)); put(24, 16'h001A);  // jump 26
    put(25, mv(8'h02, 8'h04));                     // jumped over
    put(26, mv(8'h00, 8'h03)); put(27, 16'h0083);
    put(28, mv(8'h02, 8'h04));                     // [83]
    put(29, mv(8'h01, 8'h02));                     // AC=PC
    put(30, mv(8'h00, 8'h03)); put(31, 16'h0084);
    put(32, mv(8'h02, 8'h04));                     // [84]
    put(33, mv(8'h00, 8'h1B)); put(34, 16'h0001);  // neg 1
    put(35, mv(8'h00, 8'h1C)); put(36, 16'h5555);  // reserved op
    put(37, mv(8'h00, 8'h03)); put(38, 16'h0085);
    put(39, mv(8'h02, 8'h04));                     // [85]
    put(40, mv(8'h00, 8'h01)); put(41, 16'h0028);  // loop
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    load_program();
    m_pc = 0; m_mar = 0; m_ac = 0; m_c = 0; m_skip = 0;
    while (q_addr.size() < RUN) model_instr();
    repeat (3) @(negedge clk);
    check("R1 reset addr", 32'(addr), 32'h0);
    check("R1 reset we", 32'(we), 32'h0);
    rst_n = 1'b1;  // released at a falling edge
    for (int i = 0; i < RUN; i++) begin
      check({q_tag[i], " addr"}, 32'(addr), 32'(q_addr[i]));
      check({q_tag[i], " we"}, 32'(we), 32'(q_we[i]));
      if (q_we[i]) check({q_tag[i], " wdata"}, 32'(wdata), 32'(q_wd[i]));
      @(negedge clk);
    end
    check("R7 add result", 32'(mem[8'h80]), 32'h0008);
    check("R8 borrow flag", 32'(mem[8'h81]), 32'hFFFF);
    check("R10 skip taken", 32'(mem[8'h82]), 32'h122B);
    check("R7 shl result", 32'(mem[8'h83]), 32'h22B0);
    check("R4 pc read", 32'(mem[8'h84]), 32'h001E);
    check("R11 reserved op", 32'(mem[8'h85]), 32'hFFFF);
    rst_n = 1'b0;
    #1;
    check("R1 re-reset addr", 32'(addr), 32'h0);
    check("R1 re-reset we", 32'(we), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule